// File: doc/BRIEF.md
# Byte-Wide Configuration Loader

This block runs the host side of loading an SRAM-based programmable device through its byte-wide slave parallel port. A pulse on `start` begins an attempt. The loader pulls the device's clear strobe low and waits for the device to report that it is clearing. It then releases the strobe and waits for the device's status lines to settle to idle.

Once the device is idle, the loader accepts bytes from a valid/ready source stream. It drops every byte that comes before the two-byte sync pattern 0xFF, 0x20. The first byte it writes to the device is the 0xFF of that pattern. Each byte is placed on the device data bus with its bit order reversed and is qualified by a low write strobe of fixed length. After each byte the loader watches the device status for a fixed window. When the stream ends, it appends a set number of 0xFF fill bytes, which give the device the extra clocking it needs after the last data byte.

Each attempt ends with a one-cycle success pulse or a one-cycle error pulse. Every timeout is counted in microseconds by one prescaler derived from the clock-frequency parameter. The device status inputs pass through two-flop synchronisers before the control logic uses them.

Top module: `cfg_loader`

## Requirements
- R1: After reset, `dev_wipe_n` and `dev_wr_n` are high, and `run` and `s_ready` are low. A `start` pulse in idle drives `dev_wipe_n` low and `run` high from the next cycle.
- R2: If `dev_clear_n` is not seen low within INIT_US microseconds of `dev_wipe_n` going low, the attempt ends with `err_pulse` two cycles after INIT_US*CLK_MHZ cycles have elapsed since the `start` edge, and `dev_wipe_n` returns high.
- R3: Once `dev_clear_n` is seen low, `dev_wipe_n` is released. Before any stream byte is accepted, `dev_clear_n` and `dev_stall_n` must both read high and `dev_complete` must read low; if that does not happen within CLEAR_US microseconds, the attempt ends with an error and nothing is written.
- R4: Every stream byte before the first byte pair 0xFF followed by 0x20 is accepted and never written. A run such as 0xFF 0xFF 0x20 starts the write at the 0xFF just before 0x20, and 0xFF 0x00 0x20 is not a match.
- R5: Writing begins with the 0xFF of the pattern, then 0x20, then the following stream bytes in order.
- R6: For every write, data bus bit i equals bit 7-i of the stream byte, so byte bit 7 appears on bus bit 0.
- R7: For every byte, `dev_wr_n` is low for exactly STROBE_CYC consecutive cycles, and `dev_d` stays stable during that time.
- R8: If `dev_complete` is seen high during the POLL_US status window after a byte, the attempt ends with `ok_pulse` and no further byte is accepted or written.
- R9: If the status window expires while `dev_stall_n` or `dev_clear_n` reads low, the attempt ends with an error and no further byte is written.
- R10: After the stream byte flagged with `s_last` has been written, exactly PAD_BYTES bytes of 0xFF are written. If completion is still not seen after that, the result is an error. If the stream ends before the sync pattern is found, the result is an error with no write.
- R11: `ok_pulse` and `err_pulse` each last one cycle, never occur together, occur once per attempt, and `run` is low from the cycle after either pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a configuration attempt (taken while idle) |
| s_data | input | 8 | Stream byte |
| s_valid | input | 1 | Stream byte present |
| s_last | input | 1 | Marks the final stream byte |
| s_ready | output | 1 | Loader takes the stream byte this cycle |
| dev_wipe_n | output | 1 | Active-low device clear/program strobe |
| dev_wr_n | output | 1 | Active-low byte write strobe |
| dev_d | output | 8 | Device data bus, bit-reversed byte |
| dev_clear_n | input | 1 | Device reports clearing / fault, active low |
| dev_stall_n | input | 1 | Device not ready for data, active low |
| dev_complete | input | 1 | Device reports configuration complete |
| run | output | 1 | Attempt in progress |
| ok_pulse | output | 1 | One-cycle success indication |
| err_pulse | output | 1 | One-cycle failure indication |

## Verification
The clear strobe and `run` change in the cycle after the `start` edge. A clear-phase timeout produces its error two cycles after INIT_US*CLK_MHZ cycles, and the bench checks that exact distance against a cycle counter. Device responses are seen two to three cycles after the device model changes them, because of the synchroniser and the state register. For that reason the bench waits for the single result pulse under a time limit instead of sampling one fixed cycle. All outputs are sampled on the falling edge. Write-strobe width, data stability and the written byte sequence are measured edge by edge and compared with lists that bench functions build from the stimulus.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WIPE,
    S_SETTLE,
    S_HUNT,
    S_FETCH,
    S_STROBE,
    S_POLL
  } ldr_state_t;

  function automatic logic [7:0] bit_flip(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        meta[g] <= RST_VAL[g];
        dout[g] <= RST_VAL[g];
      end else begin
        meta[g] <= din[g];
        dout[g] <= meta[g];
      end
    end
  end
endmodule

// File: rtl/cfg_timer.sv
module cfg_timer #(
  parameter int CLK_MHZ   = 250,
  parameter int LIMIT_MAX = 3000,
  parameter int UW        = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  output logic [UW-1:0] us_cnt
);
  localparam int PW = $clog2(CLK_MHZ + 1);
  localparam logic [PW-1:0] PRE_TOP = PW'(CLK_MHZ - 1);
  localparam logic [UW-1:0] SAT     = UW'(LIMIT_MAX);

  logic [PW-1:0] pre;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pre    <= '0;
      us_cnt <= '0;
    end else if (pre == PRE_TOP) begin
      pre <= '0;
      if (us_cnt != SAT) us_cnt <= us_cnt + 1'b1;
    end else begin
      pre <= pre + 1'b1;
    end
  end

  // the microsecond count only ever steps by one between clears (R2 timing base)
  assert_us_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!clr && us_cnt != SAT) |=> (us_cnt == $past(us_cnt) || us_cnt == $past(us_cnt) + 1'b1));
endmodule

// File: rtl/cfg_hunt.sv
module cfg_hunt (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       take,
  input  logic [7:0] byte_i,
  output logic       hit
);
  logic prev_ff;

  assign hit = take && prev_ff && (byte_i == 8'h20);

  always_ff @(posedge clk) begin
    if (rst || clr) prev_ff <= 1'b0;
    else if (take)  prev_ff <= (byte_i == 8'hFF);
  end
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_pkg::*;
#(
  parameter int CLK_MHZ    = 250,
  parameter int INIT_US    = 7,
  parameter int CLEAR_US   = 3000,
  parameter int POLL_US    = 16,
  parameter int STROBE_CYC = 4,
  parameter int PAD_BYTES  = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] s_data,
  input  logic       s_valid,
  input  logic       s_last,
  output logic       s_ready,
  output logic       dev_wipe_n,
  output logic       dev_wr_n,
  output logic [7:0] dev_d,
  input  logic       dev_clear_n,
  input  logic       dev_stall_n,
  input  logic       dev_complete,
  output logic       run,
  output logic       ok_pulse,
  output logic       err_pulse
);
  localparam int LMAX01 = (INIT_US > CLEAR_US) ? INIT_US : CLEAR_US;
  localparam int LMAX   = (LMAX01 > POLL_US) ? LMAX01 : POLL_US;
  localparam int UW     = $clog2(LMAX + 1);
  localparam int SW     = $clog2(STROBE_CYC + 1);
  localparam int PW     = $clog2(PAD_BYTES + 1);

  ldr_state_t state, nxt;

  logic [2:0] st_sync;
  logic       clr_s, stl_s, dne_s;
  logic [UW-1:0] us_cnt, lim;
  logic       expire, tclr;
  logic       take, hit;

  logic [7:0]    pend;
  logic          pend_v, end_seen;
  logic [PW-1:0] pad_left;
  logic [SW-1:0] scnt;

  logic       fin_ok, fin_err, ld, ld_pend, pend_use, set_end, pad_dec;
  logic [7:0] ld_val;

  cfg_sync #(.W(3), .RST_VAL(3'b011)) i_sync (
    .clk (clk),
    .rst (rst),
    .din ({dev_complete, dev_stall_n, dev_clear_n}),
    .dout(st_sync)
  );
  assign clr_s = st_sync[0];
  assign stl_s = st_sync[1];
  assign dne_s = st_sync[2];

  assign tclr = (nxt != state);

  cfg_timer #(.CLK_MHZ(CLK_MHZ), .LIMIT_MAX(LMAX), .UW(UW)) i_timer (
    .clk   (clk),
    .rst   (rst),
    .clr   (tclr),
    .us_cnt(us_cnt)
  );

  always_comb begin
    case (state)
      S_WIPE:   lim = UW'(INIT_US);
      S_SETTLE: lim = UW'(CLEAR_US);
      default:  lim = UW'(POLL_US);
    endcase
  end
  assign expire = (us_cnt >= lim);

  assign s_ready = (state == S_HUNT) || (state == S_FETCH);
  assign take    = s_valid && s_ready;

  cfg_hunt i_hunt (
    .clk   (clk),
    .rst   (rst),
    .clr   (state != S_HUNT),
    .take  (take),
    .byte_i(s_data),
    .hit   (hit)
  );

  always_comb begin
    nxt      = state;
    fin_ok   = 1'b0;
    fin_err  = 1'b0;
    ld       = 1'b0;
    ld_val   = 8'hFF;
    ld_pend  = 1'b0;
    pend_use = 1'b0;
    set_end  = 1'b0;
    pad_dec  = 1'b0;
    case (state)
      S_IDLE:   if (start) nxt = S_WIPE;
      S_WIPE: begin
        if (!clr_s)      nxt = S_SETTLE;
        else if (expire) fin_err = 1'b1;
      end
      S_SETTLE: begin
        if (clr_s && stl_s && !dne_s) nxt = S_HUNT;
        else if (expire)              fin_err = 1'b1;
      end
      S_HUNT: begin
        if (take) begin
          if (hit) begin
            ld      = 1'b1;
            ld_val  = 8'hFF;
            ld_pend = 1'b1;
            set_end = s_last;
            nxt     = S_STROBE;
          end else if (s_last) begin
            fin_err = 1'b1;
          end
        end
      end
      S_FETCH: begin
        if (take) begin
          ld      = 1'b1;
          ld_val  = s_data;
          set_end = s_last;
          nxt     = S_STROBE;
        end
      end
      S_STROBE: if (scnt == SW'(STROBE_CYC - 1)) nxt = S_POLL;
      S_POLL: begin
        if (dne_s) begin
          fin_ok = 1'b1;
        end else if (expire) begin
          if (!(clr_s && stl_s)) begin
            fin_err = 1'b1;
          end else if (pend_v) begin
            ld       = 1'b1;
            ld_val   = pend;
            pend_use = 1'b1;
            nxt      = S_STROBE;
          end else if (end_seen) begin
            if (pad_left != '0) begin
              ld      = 1'b1;
              pad_dec = 1'b1;
              nxt     = S_STROBE;
            end else begin
              fin_err = 1'b1;
            end
          end else begin
            nxt = S_FETCH;
          end
        end
      end
      default: nxt = S_IDLE;
    endcase
    if (fin_ok || fin_err) nxt = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      pend       <= '0;
      pend_v     <= 1'b0;
      end_seen   <= 1'b0;
      pad_left   <= '0;
      scnt       <= '0;
      dev_wipe_n <= 1'b1;
      dev_wr_n   <= 1'b1;
      dev_d      <= '0;
      run        <= 1'b0;
      ok_pulse   <= 1'b0;
      err_pulse  <= 1'b0;
    end else begin
      state      <= nxt;
      dev_wipe_n <= (nxt != S_WIPE);
      dev_wr_n   <= (nxt != S_STROBE);
      run        <= (nxt != S_IDLE);
      ok_pulse   <= fin_ok;
      err_pulse  <= fin_err;

      if (state == S_IDLE && start) begin
        pend_v   <= 1'b0;
        end_seen <= 1'b0;
        pad_left <= PW'(PAD_BYTES);
      end
      if (ld_pend) begin
        pend   <= s_data;
        pend_v <= 1'b1;
      end else if (pend_use) begin
        pend_v <= 1'b0;
      end
      if (ld && set_end) end_seen <= 1'b1;
      if (pad_dec) pad_left <= pad_left - 1'b1;

      if (ld) begin
        dev_d <= bit_flip(ld_val);
        scnt  <= '0;
      end else if (state == S_STROBE) begin
        scnt <= scnt + 1'b1;
      end
    end
  end

  assert_ok_err_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(ok_pulse && err_pulse));

  assert_pulse_once_R11: assert property (@(posedge clk) disable iff (rst)
    (ok_pulse || err_pulse) |=> (!ok_pulse && !err_pulse && !run));

  assert_wr_in_run_R7: assert property (@(posedge clk) disable iff (rst)
    !dev_wr_n |-> (run && dev_wipe_n));

  assert_strobe_data_R7: assert property (@(posedge clk) disable iff (rst)
    (!dev_wr_n && $past(!dev_wr_n)) |-> $stable(dev_d));

  assert_no_take_in_write_R5: assert property (@(posedge clk) disable iff (rst)
    s_ready |-> dev_wr_n);

  assert_wipe_not_with_write_R3: assert property (@(posedge clk) disable iff (rst)
    !dev_wipe_n |-> (dev_wr_n && !s_ready));
endmodule

// File: tb/test_cfg_loader.sv
module test_cfg_loader;
  localparam int CLK_MHZ = 4;
  localparam int INIT_US = 7;
  localparam int CLEAR_US = 30;
  localparam int POLL_US = 2;
  localparam int STROBE = 3;
  localparam int PAD = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [7:0] s_data = '0;
  logic s_valid = 1'b0, s_last = 1'b0;
  logic s_ready, dev_wipe_n, dev_wr_n, run, ok_pulse, err_pulse;
  logic [7:0] dev_d;
  logic mdl_clear = 1'b1, mdl_stall = 1'b1, mdl_done = 1'b0;

  always #2 clk = ~clk;

  cfg_loader #(.CLK_MHZ(CLK_MHZ), .INIT_US(INIT_US), .CLEAR_US(CLEAR_US),
               .POLL_US(POLL_US), .STROBE_CYC(STROBE), .PAD_BYTES(PAD)) i_cfg_loader (
    .clk(clk), .rst(rst), .start(start),
    .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
    .dev_wipe_n(dev_wipe_n), .dev_wr_n(dev_wr_n), .dev_d(dev_d),
    .dev_clear_n(mdl_clear), .dev_stall_n(mdl_stall), .dev_complete(mdl_done),
    .run(run), .ok_pulse(ok_pulse), .err_pulse(err_pulse)
  );

  int total = 0, bad = 0;
  int cyc = 0;
  logic [7:0] stim [0:63];
  logic [7:0] cap [0:63];
  logic [7:0] expb [0:63];
  int cap_n, exp_n, ok_cnt, err_cnt, wcount, low_len, fin_cyc, st_cyc;
  bit fin, both, bad_width, data_moved, prev_wr = 1'b1;
  logic [7:0] prev_d;
  bit init_ok = 1'b1, clear_stuck = 1'b0;
  int done_after = 1, stall_at = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] mirror(input logic [7:0] b);
    return {b[0], b[1], b[2], b[3], b[4], b[5], b[6], b[7]};
  endfunction

  // device model and observation, all on the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      if (ok_pulse) ok_cnt++;
      if (err_pulse) err_cnt++;
      if (ok_pulse && err_pulse) both = 1'b1;
      if (ok_pulse || err_pulse) begin fin = 1'b1; fin_cyc = cyc; end
      if (!dev_wr_n) begin
        if (prev_wr) begin
          if (cap_n < 64) cap[cap_n] = mirror(dev_d);
          cap_n++;
          low_len = 1;
        end else begin
          low_len++;
          if (dev_d != prev_d) data_moved = 1'b1;
        end
      end else if (!prev_wr) begin
        if (low_len != STROBE) bad_width = 1'b1;
        wcount++;
        if (wcount == done_after) mdl_done = 1'b1;
        if (wcount == stall_at) mdl_stall = 1'b0;
      end
      prev_wr = dev_wr_n;
      prev_d  = dev_d;
      if (!dev_wipe_n) begin
        mdl_clear = init_ok ? 1'b0 : 1'b1;
        mdl_done  = 1'b0;
        mdl_stall = 1'b1;
        wcount    = 0;
      end else if (!clear_stuck) begin
        mdl_clear = 1'b1;
      end
    end
  end

  task automatic chk(input bit cond, input string req, input int act, input int expv);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int find_sync(input int n);
    for (int i = 0; i + 1 < n; i++)
      if (stim[i] == 8'hFF && stim[i+1] == 8'h20) return i;
    return -1;
  endfunction

  // expected outcome and written bytes, from the requirements
  task automatic build_expect(input int n, output bit want_ok, output int want_n);
    int p, tot;
    p = find_sync(n);
    exp_n = 0;
    if (p >= 0) begin
      for (int i = p; i < n; i++) begin expb[exp_n] = stim[i]; exp_n++; end
      for (int i = 0; i < PAD; i++) begin expb[exp_n] = 8'hFF; exp_n++; end
    end
    tot = exp_n;
    want_ok = init_ok && !clear_stuck && p >= 0 && done_after <= tot &&
              (stall_at == 0 || done_after <= stall_at);
    if (want_ok) want_n = done_after;
    else if (!init_ok || clear_stuck || p < 0) want_n = 0;
    else if (stall_at != 0 && stall_at < tot) want_n = stall_at;
    else want_n = tot;
  endtask

  task automatic send_stream(input int n);
    for (int i = 0; i < n && !fin; i++) begin
      @(negedge clk);
      s_valid = 1'b1; s_data = stim[i]; s_last = (i == n - 1);
      while (!s_ready && !fin) @(negedge clk);
      if (!fin) @(posedge clk);
    end
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic wait_fin;
    int lim = 0;
    while (!fin && lim < 20000) begin @(negedge clk); lim++; end
  endtask

  task automatic run_case(input int n, input string tag);
    bit want_ok;
    int want_n, mism;
    build_expect(n, want_ok, want_n);
    cap_n = 0; ok_cnt = 0; err_cnt = 0; fin = 1'b0; both = 1'b0;
    bad_width = 1'b0; data_moved = 1'b0;
    @(negedge clk); start = 1'b1; st_cyc = cyc;
    @(negedge clk); start = 1'b0;
    chk(run && !dev_wipe_n, "R1 start drives clear strobe", {run, dev_wipe_n}, 2);
    fork
      send_stream(n);
      wait_fin;
    join
    repeat (4) @(negedge clk);
    chk(fin, {tag, " attempt ended"}, fin, 1);
    chk(ok_cnt == (want_ok ? 1 : 0) && err_cnt == (want_ok ? 0 : 1),
        {tag, " R11 outcome"}, ok_cnt * 10 + err_cnt, want_ok ? 10 : 1);
    chk(!both && !run && dev_wipe_n, "R11 idle after pulse", {both, run, dev_wipe_n}, 1);
    chk(cap_n == want_n, {tag, " write count"}, cap_n, want_n);
    mism = -1;
    for (int i = 0; i < cap_n && i < want_n && i < 64; i++)
      if (mism < 0 && cap[i] != expb[i]) mism = i;
    chk(mism < 0, "R5 R6 R10 written bytes", mism < 0 ? 0 : cap[mism], mism < 0 ? 0 : expb[mism]);
    chk(!bad_width && !data_moved, "R7 strobe width and data", {bad_width, data_moved}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int hl, bl, n, tot;
    void'($urandom(32'h2c41));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(dev_wipe_n && dev_wr_n && !run && !s_ready, "R1 reset state",
        {dev_wipe_n, dev_wr_n, run, s_ready}, 4'b1100);

    // R4 R5 R6 R8: random header, sync pair, body, completion on last fill byte
    n = 0;
    for (int i = 0; i < 5; i++) begin stim[n] = 8'($urandom % 255); n++; end
    stim[n] = 8'hFF; stim[n+1] = 8'h20; n += 2;
    for (int i = 0; i < 6; i++) begin stim[n] = 8'($urandom); n++; end
    done_after = 10;
    run_case(n, "R8");

    // R4 corner: FF 00 20 is no match, FF FF 20 is; completion mid stream
    stim[0] = 8'h11; stim[1] = 8'hFF; stim[2] = 8'h00; stim[3] = 8'h20;
    stim[4] = 8'hFF; stim[5] = 8'hFF; stim[6] = 8'h20;
    stim[7] = 8'h81; stim[8] = 8'h3C; stim[9] = 8'h01; stim[10] = 8'h55; stim[11] = 8'hAA;
    done_after = 5;
    run_case(12, "R4");

    // R10: stream ends, fill bytes written, no completion
    stim[0] = 8'h07; stim[1] = 8'h09; stim[2] = 8'hFF; stim[3] = 8'h20;
    stim[4] = 8'hC3; stim[5] = 8'h12;
    done_after = 100;
    run_case(6, "R10 fill");

    // R10: stream ends inside the header, ending on a lone FF
    stim[0] = 8'h20; stim[1] = 8'h44; stim[2] = 8'h20; stim[3] = 8'hFF;
    run_case(4, "R10 no sync");

    // R2: clear indication never arrives, exact timeout distance
    init_ok = 1'b0;
    run_case(0, "R2");
    chk(fin_cyc - st_cyc == INIT_US * CLK_MHZ + 2, "R2 timeout cycle",
        fin_cyc - st_cyc, INIT_US * CLK_MHZ + 2);
    init_ok = 1'b1;

    // R3: clear indication stuck after release
    clear_stuck = 1'b1;
    stim[0] = 8'hFF; stim[1] = 8'h20; stim[2] = 8'h01;
    done_after = 3;
    run_case(3, "R3");
    clear_stuck = 1'b0;
    mdl_clear = 1'b1;
    repeat (4) @(negedge clk);

    // R9: device stalls after the third byte
    stim[0] = 8'hFF; stim[1] = 8'h20;
    for (int i = 2; i < 8; i++) stim[i] = 8'(i * 37);
    done_after = 20; stall_at = 3;
    run_case(8, "R9");
    stall_at = 0;

    // random mix for R5 R8 R10
    for (int k = 0; k < 6; k++) begin
      hl = $urandom % 6; bl = 1 + $urandom % 8;
      n = 0;
      for (int i = 0; i < hl; i++) begin stim[n] = 8'($urandom % 255); n++; end
      stim[n] = 8'hFF; stim[n+1] = 8'h20; n += 2;
      for (int i = 0; i < bl; i++) begin stim[n] = 8'($urandom); n++; end
      tot = 2 + bl + PAD;
      done_after = 1 + ($urandom % (tot + 1));
      run_case(n, "R5 R8 R10 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule